// File: doc/BRIEF.md
# Local Bus Cycle Generator

This block turns single read or write requests from a host-side agent into one cycle on an external local bus that is 8 or 16 bits wide. The host presents a dword address, four active-low byte enables and write data. The block works out which bus address and which byte lanes to use, produces the strobes, and returns a one-cycle completion with an error flag and, for reads, the captured data.

Configuration inputs control each cycle. They choose separate read and write strobes or a read/write level with a single data strobe. They choose whether the block must first request the bus and wait for a grant. They set the data width and a 4-bit timing code. The timing code gives either a fixed strobe length in clocks or a strobe that ends when an active-low ready input is sampled low. A code or byte-enable pattern the block cannot serve ends the request at once with an error and produces no bus activity.

Top module: `lbus_cycle_gen`

## Requirements
- R1: After reset the block is idle. `req_ready` is 1, all strobes are high, and `bus_req`, `lb_bus_oe` and `resp_done` are 0.
- R2: For timing codes 4 to 11 (binary 0100 to 1011), the strobe stays asserted for exactly that many clocks. For example, 0100 gives 4 clocks, 0110 gives 6 and 1011 gives 11.
- R3: For timing code 0000, the strobe stays asserted until `lb_rdy_n` is sampled low on a rising edge with the strobe active. The strobe ends at that edge.
- R4: Timing codes 0001 to 0011 and 1100 to 1111 are illegal. An accepted request with such a code raises `resp_done` and `resp_err` in the next cycle. It produces no strobe, no `lb_bus_oe` and no `bus_req`.
- R5: With `cfg_moto`=0, a read pulses `lb_rd_n` low and a write pulses `lb_wr_n` low, and `lb_ds_n` stays high. With `cfg_moto`=1, `lb_ds_n` pulses low and `lb_rw` is 1 for a read and 0 for a write, and the other two strobes stay high.
- R6: With `cfg_arb_en`=1, the block raises `bus_req` and drives nothing (`lb_bus_oe`=0) until `bus_gnt` is seen high. With `cfg_arb_en`=0, `bus_req` is never raised.
- R7: After the strobe deasserts, address, byte-high enable and write data stay driven and unchanged for exactly one more clock. `bus_req` drops in the clock after that.
- R8: In 8-bit mode (`cfg_wide`=0), a single enabled byte lane i (byte-enable values 1110, 1101, 1011 and 0111 give i = 0, 1, 2 and 3) sets `lb_addr` = {req_addr[19:2], i[1:0]}. In this mode `lb_bhe_n` stays 1 and `lb_wdata` = {8'h00, write byte i}.
- R9: In 16-bit mode, lanes 0-1 or lanes 2-3 form the active pair. Bit 1 of the address is 1 when the upper pair is used. Bit 0 of the address equals the pair's low-lane enable, and `lb_bhe_n` equals the pair's high-lane enable. `lb_wdata` is the matching 16-bit half of the write data.
- R10: A byte-enable pattern that is not served gives an immediate error with no bus activity. In 8-bit mode that is anything other than exactly one enabled lane. In 16-bit mode it is any pattern with no lane enabled, or with lanes enabled in both pairs.
- R11: A read returns the bus data sampled at the edge that ends the strobe. In 16-bit mode `resp_rdata` holds it in both halves, and in 8-bit mode its low byte appears in all four lanes.
- R12: `resp_done` is a one-clock pulse. `req_ready` is 1 only when the block is idle, and `resp_done` only rises while it is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_time | input | 4 | Timing code: 0 means ready-terminated, 4-11 give a fixed length, other values are illegal |
| cfg_moto | input | 1 | 0: separate read/write strobes; 1: read/write level plus data strobe |
| cfg_arb_en | input | 1 | Request and wait for the bus before each cycle |
| cfg_wide | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| req_valid | input | 1 | Request present, taken when req_ready is 1 |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 20 | Host address, dword granular (bits 1:0 unused) |
| req_be | input | 4 | Active-low byte enables |
| req_wdata | input | 32 | Write data |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Error flag, valid with resp_done |
| resp_rdata | output | 32 | Read data, valid with resp_done |
| lb_addr | output | 20 | Bus address |
| lb_bhe_n | output | 1 | Active-low high byte enable |
| lb_wdata | output | 16 | Bus write data |
| lb_wdata_oe | output | 1 | Write data drive enable |
| lb_rdata | input | 16 | Bus read data |
| lb_bus_oe | output | 1 | Address and control drive enable |
| lb_rd_n | output | 1 | Active-low read strobe |
| lb_wr_n | output | 1 | Active-low write strobe |
| lb_rw | output | 1 | Read/write level (1 = read) |
| lb_ds_n | output | 1 | Active-low data strobe |
| lb_rdy_n | input | 1 | Active-low ready, used with code 0000 |
| bus_req | output | 1 | Bus hold request |
| bus_gnt | input | 1 | Bus hold acknowledge |

## Verification
The properties assume that the configuration inputs change only while the block is idle. They also assume that a grant, once given, stays high until `bus_req` falls. The bench sets the configuration one clock before each request and drops `req_valid` after one clock, so no request is ever presented while a cycle is running. The modelled arbiter raises the grant two clocks after seeing the request and holds it while the request stays high. The modelled target asserts ready only while a strobe is active and releases it at once.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    localparam int LB_AW   = 20;
    localparam int LB_DW   = 16;
    localparam int HOST_DW = 32;
    localparam int BE_W    = HOST_DW / 8;
    localparam int CODE_W  = 4;
    localparam int CNT_W   = CODE_W;
    localparam logic [CODE_W-1:0] CODE_RDY    = '0;
    localparam logic [CODE_W-1:0] CODE_MIN    = CODE_W'(4);
    localparam logic [CODE_W-1:0] CODE_MAX    = CODE_W'(11);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARB,
        ST_STRB,
        ST_TAIL
    } lb_state_e;

    typedef struct packed {
        logic             write;
        logic             moto;
        logic             arb;
        logic             wide;
        logic             rdy_mode;
        logic             bhe_n;
        logic [LB_AW-1:0] addr;
        logic [LB_DW-1:0] wdata;
    } lb_txn_t;

    function automatic logic code_ok(input logic [CODE_W-1:0] c);
        return (c == CODE_RDY) || ((c >= CODE_MIN) && (c <= CODE_MAX));
    endfunction

endpackage

// File: rtl/lbus_lane_map.sv
module lbus_lane_map
    import lbus_pkg::*;
#(
    parameter int AW  = LB_AW,
    parameter int HDW = HOST_DW,
    parameter int BDW = LB_DW
) (
    input  logic              wide,
    input  logic [HDW/8-1:0]  be_n,
    input  logic [AW-1:2]     addr_hi,
    input  logic [HDW-1:0]    wdata,
    output logic              map_ok,
    output logic [AW-1:0]     addr_o,
    output logic              bhe_n_o,
    output logic [BDW-1:0]    wdata_o
);
    localparam int NLANE = HDW / 8;

    logic [NLANE-1:0] lane_hit;
    logic [1:0]       lane_idx;
    logic [7:0]       lane_byte;
    logic             up_sel;
    logic [1:0]       pair;
    logic             lo_any, hi_any;

    // Exactly-one-lane detect and lane encode for the narrow bus
    genvar g;
    generate
        for (g = 0; g < NLANE; g++) begin : g_lane
            assign lane_hit[g] = (be_n == ~(NLANE'(1) << g));
        end
    endgenerate

    always_comb begin
        lane_idx = '0;
        for (int i = 0; i < NLANE; i++) begin
            if (lane_hit[i]) lane_idx = 2'(i);
        end
        lane_byte = wdata[lane_idx*8 +: 8];
    end

    assign lo_any = (be_n[1:0] != 2'b11);
    assign hi_any = (be_n[3:2] != 2'b11);
    assign up_sel = !lo_any;
    assign pair   = up_sel ? be_n[3:2] : be_n[1:0];

    always_comb begin
        if (wide) begin
            map_ok  = lo_any ^ hi_any;
            addr_o  = {addr_hi, up_sel, pair[0]};
            bhe_n_o = pair[1];
            wdata_o = up_sel ? wdata[2*BDW-1:BDW] : wdata[BDW-1:0];
        end else begin
            map_ok  = |lane_hit;
            addr_o  = {addr_hi, lane_idx};
            bhe_n_o = 1'b1;
            wdata_o = {{(BDW-8){1'b0}}, lane_byte};
        end
    end

endmodule

// File: rtl/lbus_cycle_timer.sv
module lbus_cycle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - W'(1);
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/lbus_cycle_gen.sv
module lbus_cycle_gen
    import lbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CODE_W-1:0]  cfg_time,
    input  logic               cfg_moto,
    input  logic               cfg_arb_en,
    input  logic               cfg_wide,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [LB_AW-1:0]   req_addr,
    input  logic [BE_W-1:0]    req_be,
    input  logic [HOST_DW-1:0] req_wdata,
    output logic               resp_done,
    output logic               resp_err,
    output logic [HOST_DW-1:0] resp_rdata,
    output logic [LB_AW-1:0]   lb_addr,
    output logic               lb_bhe_n,
    output logic [LB_DW-1:0]   lb_wdata,
    output logic               lb_wdata_oe,
    input  logic [LB_DW-1:0]   lb_rdata,
    output logic               lb_bus_oe,
    output logic               lb_rd_n,
    output logic               lb_wr_n,
    output logic               lb_rw,
    output logic               lb_ds_n,
    input  logic               lb_rdy_n,
    output logic               bus_req,
    input  logic               bus_gnt
);
    lb_state_e        state;
    lb_txn_t          txn;
    logic [LB_DW-1:0] rdata_q;
    logic             done_q, err_q;

    logic             map_ok;
    logic [LB_AW-1:0] map_addr;
    logic             map_bhe_n;
    logic [LB_DW-1:0] map_wdata;
    logic             accept, good, tmr_load, tmr_exp, end_now, strobe;
    logic [CNT_W-1:0] tmr_val;

    lbus_lane_map #(.AW(LB_AW), .HDW(HOST_DW), .BDW(LB_DW)) map_i (
        .wide    (cfg_wide),
        .be_n    (req_be),
        .addr_hi (req_addr[LB_AW-1:2]),
        .wdata   (req_wdata),
        .map_ok  (map_ok),
        .addr_o  (map_addr),
        .bhe_n_o (map_bhe_n),
        .wdata_o (map_wdata)
    );

    assign accept   = (state == ST_IDLE) && req_valid;
    assign good     = code_ok(cfg_time) && map_ok;
    assign tmr_load = (accept && good && !cfg_arb_en) ||
                      ((state == ST_ARB) && bus_gnt);
    // Length minus one: the strobe covers the load cycle's successor through expiry
    assign tmr_val  = (state == ST_IDLE) ? (cfg_time - CNT_W'(1))
                                         : (txn_len - CNT_W'(1));

    logic [CNT_W-1:0] txn_len;

    lbus_cycle_timer #(.W(CNT_W)) tmr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (strobe),
        .expired  (tmr_exp)
    );

    assign strobe  = (state == ST_STRB);
    assign end_now = txn.rdy_mode ? !lb_rdy_n : tmr_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            txn     <= '0;
            txn_len <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (!good) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else begin
                            txn.write    <= req_write;
                            txn.moto     <= cfg_moto;
                            txn.arb      <= cfg_arb_en;
                            txn.wide     <= cfg_wide;
                            txn.rdy_mode <= (cfg_time == CODE_RDY);
                            txn.bhe_n    <= map_bhe_n;
                            txn.addr     <= map_addr;
                            txn.wdata    <= map_wdata;
                            txn_len      <= cfg_time;
                            state        <= cfg_arb_en ? ST_ARB : ST_STRB;
                        end
                    end
                end
                ST_ARB: begin
                    if (bus_gnt) state <= ST_STRB;
                end
                ST_STRB: begin
                    if (end_now) begin
                        rdata_q <= lb_rdata;
                        state   <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                    err_q  <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready   = (state == ST_IDLE);
    assign resp_done   = done_q;
    assign resp_err    = err_q;
    assign resp_rdata  = txn.wide ? {2{rdata_q}} : {4{rdata_q[7:0]}};

    assign lb_bus_oe   = (state == ST_STRB) || (state == ST_TAIL);
    assign lb_addr     = lb_bus_oe ? txn.addr : '0;
    assign lb_bhe_n    = lb_bus_oe ? txn.bhe_n : 1'b1;
    assign lb_wdata_oe = lb_bus_oe && txn.write;
    assign lb_wdata    = lb_wdata_oe ? txn.wdata : '0;
    assign lb_rd_n     = !(strobe && !txn.moto && !txn.write);
    assign lb_wr_n     = !(strobe && !txn.moto && txn.write);
    assign lb_ds_n     = !(strobe && txn.moto);
    assign lb_rw       = !(lb_bus_oe && txn.moto && txn.write);
    assign bus_req     = txn.arb && (state != ST_IDLE);

endmodule

// File: rtl/lbus_cycle_gen_chk.sv
module lbus_cycle_gen_chk
    import lbus_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] cfg_time,
    input logic              cfg_arb_en,
    input logic              cfg_wide,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_done,
    input logic              resp_err,
    input logic [LB_AW-1:0]  lb_addr,
    input logic              lb_bhe_n,
    input logic              lb_bus_oe,
    input logic              lb_rd_n,
    input logic              lb_wr_n,
    input logic              lb_ds_n,
    input logic              bus_req,
    input logic              bus_gnt
);
    logic stb;
    logic bad_code;
    assign stb      = !lb_rd_n || !lb_wr_n || !lb_ds_n;
    assign bad_code = !((cfg_time == 4'd0) || ((cfg_time >= 4'd4) && (cfg_time <= 4'd11)));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!stb && !lb_bus_oe));

    p_illegal_err_r4: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid && bad_code) |=> (resp_done && resp_err));

    p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!lb_rd_n, !lb_wr_n, !lb_ds_n}));

    p_grant_held_r6: assert property (@(posedge clk) disable iff (rst)
        (lb_bus_oe && cfg_arb_en) |-> bus_gnt);

    p_no_request_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg_arb_en |-> !bus_req);

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (lb_bus_oe && $past(lb_bus_oe)) |-> ($stable(lb_addr) && $stable(lb_bhe_n)));

    p_req_release_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(stb) |=> !bus_req);

    p_bhe_narrow_r8: assert property (@(posedge clk) disable iff (rst)
        (lb_bus_oe && !cfg_wide) |-> lb_bhe_n);

    p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
        resp_done |-> req_ready);

endmodule

bind lbus_cycle_gen lbus_cycle_gen_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_time   (cfg_time),
    .cfg_arb_en (cfg_arb_en),
    .cfg_wide   (cfg_wide),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_done  (resp_done),
    .resp_err   (resp_err),
    .lb_addr    (lb_addr),
    .lb_bhe_n   (lb_bhe_n),
    .lb_bus_oe  (lb_bus_oe),
    .lb_rd_n    (lb_rd_n),
    .lb_wr_n    (lb_wr_n),
    .lb_ds_n    (lb_ds_n),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt)
);

// File: tb/lbus_cycle_gen_tb_top.sv
module lbus_cycle_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_time = 4'd4;
    logic        cfg_moto = 1'b0;
    logic        cfg_arb_en = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_be = 4'hF;
    logic [31:0] req_wdata = '0;
    logic        resp_done, resp_err;
    logic [31:0] resp_rdata;
    logic [19:0] lb_addr;
    logic        lb_bhe_n;
    logic [15:0] lb_wdata;
    logic        lb_wdata_oe;
    logic [15:0] lb_rdata = '0;
    logic        lb_bus_oe, lb_rd_n, lb_wr_n, lb_rw, lb_ds_n;
    logic        lb_rdy_n = 1'b1;
    logic        bus_req;
    logic        bus_gnt = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lbus_cycle_gen dut_i (
        .clk(clk), .rst(rst), .cfg_time(cfg_time), .cfg_moto(cfg_moto),
        .cfg_arb_en(cfg_arb_en), .cfg_wide(cfg_wide), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .resp_done(resp_done),
        .resp_err(resp_err), .resp_rdata(resp_rdata), .lb_addr(lb_addr),
        .lb_bhe_n(lb_bhe_n), .lb_wdata(lb_wdata), .lb_wdata_oe(lb_wdata_oe),
        .lb_rdata(lb_rdata), .lb_bus_oe(lb_bus_oe), .lb_rd_n(lb_rd_n),
        .lb_wr_n(lb_wr_n), .lb_rw(lb_rw), .lb_ds_n(lb_ds_n),
        .lb_rdy_n(lb_rdy_n), .bus_req(bus_req), .bus_gnt(bus_gnt)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] tgt_data(input logic [19:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction

    task automatic run_txn(input bit moto, input bit arb, input bit wide,
                           input logic [3:0] code, input bit wr,
                           input logic [3:0] be, input logic [19:0] addr,
                           input logic [31:0] wd, input int dly);
        bit          code_legal, map_legal, legal;
        int          zeros, lane, scount, tail, post_req, act, kind_bad;
        int          addr_bad, data_bad, gnt_bad, gcnt, ncyc;
        bit          seen_stb;
        logic [19:0] exp_a;
        logic        exp_bhe, up;
        logic [1:0]  pair;
        logic [15:0] exp_wd;
        logic [31:0] exp_rd;
        int          exp_cnt;

        code_legal = (code == 4'd0) || (code >= 4'd4 && code <= 4'd11);
        zeros = 0; lane = 0;
        for (int i = 0; i < 4; i++) if (!be[i]) begin zeros++; lane = i; end
        if (wide) begin
            up        = (be[1:0] == 2'b11);
            pair      = up ? be[3:2] : be[1:0];
            map_legal = (be[1:0] != 2'b11) ^ (be[3:2] != 2'b11);
            exp_a     = {addr[19:2], up, pair[0]};
            exp_bhe   = pair[1];
            exp_wd    = up ? wd[31:16] : wd[15:0];
        end else begin
            map_legal = (zeros == 1);
            exp_a     = {addr[19:2], 2'(lane)};
            exp_bhe   = 1'b1;
            exp_wd    = {8'h00, wd[lane*8 +: 8]};
        end
        legal   = code_legal && map_legal;
        exp_cnt = (code == 4'd0) ? dly : int'(code);
        exp_rd  = wide ? {2{tgt_data(exp_a)}} : {4{tgt_data(exp_a)[7:0]}};

        scount = 0; tail = 0; post_req = 0; act = 0; kind_bad = 0;
        addr_bad = 0; data_bad = 0; gnt_bad = 0; gcnt = 0; ncyc = 0;
        seen_stb = 1'b0;

        cfg_moto = moto; cfg_arb_en = arb; cfg_wide = wide; cfg_time = code;
        bus_gnt = 1'b0; lb_rdy_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_be = be; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;

        while (!resp_done && ncyc < 100) begin
            logic stb;
            stb = !lb_rd_n || !lb_wr_n || !lb_ds_n;
            if (stb) begin
                scount++;
                seen_stb = 1'b1;
                if (!moto && !(wr ? (!lb_wr_n && lb_rd_n && lb_ds_n)
                                  : (!lb_rd_n && lb_wr_n && lb_ds_n))) kind_bad++;
                if (moto && !(!lb_ds_n && lb_rd_n && lb_wr_n && (lb_rw == !wr))) kind_bad++;
            end
            if (lb_bus_oe && !stb) tail++;
            if (lb_bus_oe) begin
                if (lb_addr != exp_a || lb_bhe_n != exp_bhe) addr_bad++;
                if (lb_wdata_oe != wr || (wr && lb_wdata != exp_wd)) data_bad++;
            end
            if (arb) begin
                if (lb_bus_oe && !bus_gnt) gnt_bad++;
            end else if (bus_req) gnt_bad++;
            if (seen_stb && !lb_bus_oe && bus_req) post_req++;
            if (!legal && (lb_bus_oe || bus_req || stb)) act++;
            // Target models: grant two clocks after request, ready on the chosen strobe clock
            if (bus_req) begin gcnt++; bus_gnt = (gcnt >= 2); end
            else begin gcnt = 0; bus_gnt = 1'b0; end
            lb_rdy_n = !((code == 4'd0) && stb && (scount == dly));
            lb_rdata = tgt_data(lb_addr);
            @(negedge clk);
            ncyc++;
        end
        lb_rdy_n = 1'b1;

        chk(resp_done == 1'b1, "R12", "done seen", resp_done, 1);
        chk(resp_err == !legal, legal ? "R4" : (code_legal ? "R10" : "R4"),
            "err flag", resp_err, !legal);
        chk(!bus_req && !lb_bus_oe, "R7", "released at done", {bus_req, lb_bus_oe}, 0);
        if (legal) begin
            chk(scount == exp_cnt, (code == 0) ? "R3" : "R2", "strobe clocks", scount, exp_cnt);
            chk(tail == 1, "R7", "tail clocks", tail, 1);
            chk(post_req == 0, "R7", "late bus_req clocks", post_req, 0);
            chk(kind_bad == 0, "R5", "strobe style errors", kind_bad, 0);
            chk(gnt_bad == 0, "R6", "grant violations", gnt_bad, 0);
            chk(addr_bad == 0, wide ? "R9" : "R8", "addr/bhe mismatches", addr_bad, 0);
            chk(data_bad == 0, wide ? "R9" : "R8", "write data mismatches", data_bad, 0);
            if (!wr) chk(resp_rdata == exp_rd, "R11", "read data", resp_rdata, exp_rd);
        end else begin
            chk(act == 0, code_legal ? "R10" : "R4", "bus activity", act, 0);
            chk(ncyc == 0, "R4", "error latency", ncyc, 0);
        end
        @(negedge clk);
        chk(resp_done == 1'b0, "R12", "done width", resp_done, 0);
        chk(req_ready == 1'b1, "R12", "ready when idle", req_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk({lb_rd_n, lb_wr_n, lb_ds_n} == 3'b111, "R1", "strobes", {lb_rd_n, lb_wr_n, lb_ds_n}, 7);
        chk(!bus_req && !lb_bus_oe && !resp_done, "R1", "req/oe/done",
            {bus_req, lb_bus_oe, resp_done}, 0);

        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 2; a++)
                for (int w = 0; w < 2; w++)
                    for (int c = 0; c < 16; c++)
                        for (int d = 0; d < 2; d++)
                            run_txn(m[0], a[0], w[0], 4'(c), d[0],
                                    w[0] ? 4'b0011 : 4'b1011,
                                    20'(32'h3A5C4 + c * 20'h111 + m * 8 + a * 4),
                                    32'hC3D2E1F0 ^ (c * 32'h01010101),
                                    (c + m + d) % 3 + 1);

        for (int w = 0; w < 2; w++)
            for (int b = 0; b < 16; b++)
                for (int d = 0; d < 2; d++)
                    run_txn(1'b0, 1'b0, w[0], 4'd4, d[0], 4'(b),
                            20'(32'h5B700 + b * 16), 32'h89ABCDEF, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule